// File: doc/BRIEF.md
# Shift-and-XOR ALU Slice with Condition Flags

This block is the exclusive-OR lane of an integer execute stage. A first operand is combined by bitwise XOR with a second operand. Before the XOR, the second operand goes through an immediate-controlled barrel shifter. The shifter is steered by a 2-bit shift kind and a 5-bit amount field. The shifter also takes the incoming carry flag and returns a carry-out, which the flag logic uses.

The block returns the result and the next value of the four condition flags. The flags are packed as {N, Z, C, V} in bits [3:2:1:0] of `flags_i` and `flags_o`. Every input completes in the same fixed time. By default the result and the flags are registered, so an input presented before a rising clock edge appears on the outputs after that edge. Setting `REG_OUT` to 0 makes the path purely combinational. Decoding the operands, reading the register file and evaluating conditions all happen outside the block.

Top module: `xor_shift_alu`

## Requirements
- R1: The shift kind field `sh_type_i` decodes as 00 = logical left, 01 = logical right, 10 = arithmetic right and 11 = rotate right. For amount field values 1 to 31, the second operand is shifted by that many bits, and the carry-out is the last bit shifted out: bit (32 − amount) for a left shift, and bit (amount − 1) for the three right kinds.
- R2: A logical left shift with amount field 0 passes the operand unchanged, and the carry-out equals the incoming C flag.
- R3: With amount field 0, a logical right shift acts as a shift by 32: the value is zero and the carry-out is operand bit 31. With amount field 0, an arithmetic right shift gives 32 copies of bit 31, and the carry-out is bit 31.
- R4: Rotate right with amount field 0 is a one-bit rotate through carry. The value is {incoming C, operand[31:1]} and the carry-out is operand bit 0.
- R5: `result_o` equals `op_a_i` XOR the shifted second operand.
- R6: When `set_flags_i` is 1, N is result bit 31, Z is 1 exactly when the result is all zeros, C is the shifter carry-out, and V is copied from `flags_i` bit 0.
- R7: When `set_flags_i` is 0, `flags_o` equals `flags_i` unchanged.
- R8: With `REG_OUT` = 1, the outputs take values one clock edge after the inputs for every input pattern. While `rst_ni` is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand, which is shifted |
| sh_type_i | input | 2 | Shift kind (see R1) |
| sh_amt_i | input | 5 | Immediate shift amount field |
| set_flags_i | input | 1 | Update the flags from the result |
| flags_i | input | 4 | Current {N,Z,C,V}; C is the shifter carry-in |
| result_o | output | 32 | XOR result |
| flags_o | output | 4 | Next {N,Z,C,V} |

## Verification
The hardest cases to reach are the zero-amount field values. In those cases the same field means pass-through, a shift by 32 or a rotate through carry, depending on the shift kind. The carry-out then comes from a different source in each case: the carry-in, bit 31 or bit 0. The bench sweeps every shift kind against every amount value and both carry-in values. It uses operand patterns whose bit 0 and bit 31 differ from the carry-in, so a wrong carry source shows up in C. A zero second operand with a matching first operand forces the Z flag set.

// File: rtl/xsa_pkg.sv
package xsa_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } sh_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/xsa_shifter.sv
module xsa_shifter
  import xsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  sh_kind_e          kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] val_o,
  output logic              cout_o
);
  localparam int MSB = DATA_W - 1;

  logic [AMT_W-1:0]         amt_m1;
  logic [DATA_W-1:0]        lsl_pre, lsr_pre, ror_val;
  logic signed [DATA_W-1:0] asr_pre;

  // shift by amount-1 so the last bit out sits at an edge
  assign amt_m1  = amt_i - 1'b1;
  assign lsl_pre = val_i << amt_m1;
  assign lsr_pre = val_i >> amt_m1;
  assign asr_pre = $signed(val_i) >>> amt_m1;
  assign ror_val = (val_i >> amt_i) | (val_i << (DATA_W - int'(amt_i)));

  always_comb begin
    val_o  = val_i;
    cout_o = cin_i;
    unique case (kind_i)
      SH_LSL: if (amt_i != '0) begin
        val_o  = lsl_pre << 1;
        cout_o = lsl_pre[MSB];
      end
      SH_LSR: if (amt_i == '0) begin
        val_o  = '0;
        cout_o = val_i[MSB];
      end else begin
        val_o  = lsr_pre >> 1;
        cout_o = lsr_pre[0];
      end
      SH_ASR: if (amt_i == '0) begin
        val_o  = {DATA_W{val_i[MSB]}};
        cout_o = val_i[MSB];
      end else begin
        val_o  = $unsigned(asr_pre >>> 1);
        cout_o = asr_pre[0];
      end
      SH_ROR: if (amt_i == '0) begin
        val_o  = {cin_i, val_i[MSB:1]};
        cout_o = val_i[0];
      end else begin
        val_o  = ror_val;
        cout_o = lsr_pre[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xsa_flag_unit.sv
module xsa_flag_unit
  import xsa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              cout_i,
  input  logic              set_i,
  input  flags_t            cur_i,
  output flags_t            nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (set_i) begin
      nxt_o.n = res_i[DATA_W-1];
      nxt_o.z = (res_i == '0);
      nxt_o.c = cout_i;
    end
  end
endmodule

// File: rtl/xor_shift_alu.sv
module xor_shift_alu
  import xsa_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int AMT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [1:0]        sh_type_i,
  input  logic [AMT_W-1:0]  sh_amt_i,
  input  logic              set_flags_i,
  input  logic [3:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o
);
  logic [DATA_W-1:0] shifted, xor_res;
  logic              sh_cout;
  flags_t            cur_flags, nxt_flags;

  assign cur_flags = flags_t'(flags_i);

  xsa_shifter #(.DATA_W(DATA_W)) u_shifter (
    .val_i  (op_b_i),
    .kind_i (sh_kind_e'(sh_type_i)),
    .amt_i  (sh_amt_i),
    .cin_i  (cur_flags.c),
    .val_o  (shifted),
    .cout_o (sh_cout)
  );

  assign xor_res = op_a_i ^ shifted;

  xsa_flag_unit #(.DATA_W(DATA_W)) u_flags (
    .res_i  (xor_res),
    .cout_i (sh_cout),
    .set_i  (set_flags_i),
    .cur_i  (cur_flags),
    .nxt_o  (nxt_flags)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          result_o <= '0;
          flags_o  <= '0;
        end else begin
          result_o <= xor_res;
          flags_o  <= nxt_flags;
        end
      end
    end else begin : g_comb
      assign result_o = xor_res;
      assign flags_o  = nxt_flags;
    end
  endgenerate
endmodule

// File: rtl/xsa_chk.sv
module xsa_chk #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int AMT_W  = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic [1:0]        sh_type_i,
  input logic [AMT_W-1:0]  sh_amt_i,
  input logic              set_flags_i,
  input logic [3:0]        flags_i,
  input logic [DATA_W-1:0] result_o,
  input logic [3:0]        flags_o
);
  generate
    if (REG_OUT) begin : g_seq
      AST_V_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> flags_o[0] == $past(flags_i[0]));                          // R6
      AST_FLAGS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !set_flags_i |=> flags_o == $past(flags_i));                        // R7
      AST_Z_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_flags_i |=> flags_o[2] == (result_o == '0));                    // R6
      AST_N_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_flags_i |=> flags_o[3] == result_o[DATA_W-1]);                  // R6
      AST_ZERO_B_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_b_i == '0 && sh_type_i != 2'b11) |=> result_o == $past(op_a_i)); // R5
      AST_LSL0_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_flags_i && sh_type_i == 2'b00 && sh_amt_i == '0)
          |=> flags_o[1] == $past(flags_i[1]));                             // R2
      AST_RRX_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_flags_i && sh_type_i == 2'b11 && sh_amt_i == '0)
          |=> flags_o[1] == $past(op_b_i[0]));                              // R4
    end else begin : g_comb
      always_comb begin
        if (rst_ni && !set_flags_i)
          AST_FLAGS_HELD_C: assert (flags_o == flags_i);                    // R7
        if (rst_ni)
          AST_V_KEPT_C: assert (flags_o[0] == flags_i[0]);                  // R6
      end
    end
  endgenerate
endmodule

bind xor_shift_alu xsa_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/xor_shift_alu_tb.sv
module xor_shift_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  sh_type = '0;
  logic [4:0]  sh_amt = '0;
  logic        set_fl = 1'b0;
  logic [3:0]  fl_in = '0;
  logic [31:0] result;
  logic [3:0]  fl_out;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  xor_shift_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(op_a), .op_b_i(op_b),
    .sh_type_i(sh_type), .sh_amt_i(sh_amt), .set_flags_i(set_fl),
    .flags_i(fl_in), .result_o(result), .flags_o(fl_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (type=%0d amt=%0d cin=%0b b=%h)",
               tag, act, exp, sh_type, sh_amt, fl_in[1], op_b);
    end
  endtask

  // reference shifter built from wide arithmetic
  function automatic logic [32:0] ref_shift(input logic [31:0] b, input logic [1:0] t,
                                            input int k, input logic cin);
    logic [63:0] w;
    logic [31:0] fill;
    case (t)
      2'd0: begin
        if (k == 0) return {cin, b};
        w = {32'd0, b} << k;
        return {w[32], w[31:0]};
      end
      2'd3: begin
        if (k == 0) return {b[0], cin, b[31:1]};
        w = {b, b} >> k;
        return {w[31], w[31:0]};
      end
      default: begin
        if (k == 0) k = 32;
        fill = (t == 2'd2 && b[31]) ? 32'hFFFF_FFFF : 32'd0;
        w = {fill, b} >> (k - 1);
        return {w[0], w[32:1]};
      end
    endcase
  endfunction

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [1:0] t,
                     input int k, input logic sf, input logic [3:0] fi);
    logic [32:0] r;
    logic [31:0] er;
    logic [3:0]  ef;
    string       tag;
    @(negedge clk);
    op_a = a; op_b = b; sh_type = t; sh_amt = 5'(k); set_fl = sf; fl_in = fi;
    r  = ref_shift(b, t, k, fi[1]);
    er = a ^ r[31:0];
    ef = sf ? {er[31], (er == 32'd0), r[32], fi[0]} : fi;
    if (k != 0) tag = "R1";
    else if (t == 2'd0) tag = "R2";
    else if (t == 2'd3) tag = "R4";
    else tag = "R3";
    @(posedge clk);
    @(negedge clk);
    chk({tag, "/R5 result"}, result, er);
    chk(sf ? {tag, "/R6 flags"} : "R7 flags held", 32'(fl_out), 32'(ef));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R8: watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hFFFF_FFFF;
    pats[3] = 32'h0000_0000; pats[4] = 32'hA5C3_0F96; pats[5] = 32'h5A3C_F069;
    op_a = 32'hDEAD_BEEF; fl_in = 4'hF; set_fl = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 reset result", result, 32'd0);        // R8
    chk("R8 reset flags", 32'(fl_out), 32'd0);    // R8
    rst_n = 1'b1;
    for (int t = 0; t < 4; t++)
      for (int k = 0; k < 32; k++)
        for (int c = 0; c < 2; c++)
          for (int p = 0; p < 6; p++)
            for (int s = 0; s < 2; s++)
              run(pats[(p + k) % 6], pats[p], 2'(t), k, s[0],
                  {2'b01, c[0], p[0]});
    // R5: zero operand gives Z, equal operands under pass-through
    run(32'h1234_5678, 32'h1234_5678, 2'd0, 0, 1'b1, 4'b0001);
    run(32'h0000_0000, 32'h0000_0000, 2'd1, 0, 1'b1, 4'b0010);
    // random sweep
    for (int i = 0; i < 2000; i++)
      run($urandom, $urandom, 2'($urandom), int'($urandom % 32), 1'($urandom),
          4'($urandom));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule